// File: doc/BRIEF.md
# Network Utilization Bar-Graph Meter

This block estimates how busy a shared network medium is and shows the result on an eight-LED bar graph. It divides time into fixed sampling windows of 2^WIN_LOG2 clock cycles. During each window it counts the cycles in which carrier sense is high.

When a window closes, the block does three things in turn. It latches the busy count. It turns the count into a utilization band and updates the bar. It clears the counter so the next window starts from zero. The bands are logarithmic: each LED threshold is roughly double the one below it, with 80% as the top step. The bar therefore shows the difference between a quiet segment and a lightly loaded one, and still marks a saturated one.

The LED outputs are active low. They stay constant for the whole of a window.

Top module: `util_meter`

## Requirements
- R1: While reset is asserted, and after its release until the first window has completed, all eight outputs `act_n` are high (every LED off).
- R2: A sampling window lasts exactly 2^WIN_LOG2 clock cycles. The first window begins on the first rising edge after reset is released, and each window starts on the edge after the previous one ends.
- R3: The busy count of a window includes every sampled cycle of that window in which `crs` is high, the last cycle included. The counter starts each window from zero, so nothing carries over from the window before.
- R4: The number of lit LEDs equals the number of percentages in the set {1, 2, 4, 8, 16, 32, 64, 80} that are strictly below the window's utilization. Utilization is busy/2^WIN_LOG2, so a percentage p is exceeded when busy*100 > p*2^WIN_LOG2.
- R5: The bar fills from bit 0 upward. `act_n[i]` is low exactly when more than i LEDs are lit, so bit 0 belongs to the 1% threshold and bit 7 to the 80% threshold.
- R6: `act_n` changes only on the rising edge one cycle after the last cycle of a window. At all other times it holds its value, whatever `crs` does.
- R7: The displayed band depends only on how many busy cycles a window has, not on how they are arranged within it (one contiguous burst or spread across the window).
- R8: A window with carrier high on every cycle lights all eight LEDs. A window with no carrier lights none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| crs | input | 1 | Network carrier sense, sampled once per cycle |
| act_n | output | 8 | Bar-graph LED drives, active low, bit 0 lowest band |

## Verification
The bench builds the block with WIN_LOG2 = 10. This shortens each window to 1024 cycles, so more than twenty complete windows fit in a short run. At this size every threshold falls at a small integer busy count: 10, 20, 40, 81, 163, 327, 655 and 819. The bench can therefore drive windows exactly on each threshold and one cycle past it, and confirm that each band begins with the next busy cycle. Smaller windows also make it cheap to check the cycle just before each update, a point in the middle of each window, and the update cycle itself, which shows the exact update timing and that the bar holds steady between updates.

// File: rtl/util_meter_pkg.sv
package util_meter_pkg;

  localparam int NUM_LEDS = 8;

  // Utilization percentage that must be exceeded to light LED idx.
  function automatic int unsigned band_pct(input int idx);
    case (idx)
      0: band_pct = 1;
      1: band_pct = 2;
      2: band_pct = 4;
      3: band_pct = 8;
      4: band_pct = 16;
      5: band_pct = 32;
      6: band_pct = 64;
      default: band_pct = 80;
    endcase
  endfunction

  // Busy-cycle count that must be exceeded for LED idx (floor of win*pct/100).
  function automatic longint unsigned band_cycles(input int win_log2, input int idx);
    longint unsigned win;
    win = longint'(1) << win_log2;
    band_cycles = (win * longint'(band_pct(idx))) / 100;
  endfunction

endpackage

// File: rtl/util_busy_counter.sv
module util_busy_counter #(
  parameter int WIN_LOG2 = 20,
  localparam int CW = WIN_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          crs,
  output logic [CW-1:0] busy_latched,
  output logic          win_done
);

  localparam logic [CW-1:0] WIN_CYCLES = CW'(1) << WIN_LOG2;

  logic [WIN_LOG2-1:0] pos_q;
  logic [CW-1:0]       busy_q;
  logic                win_last;

  assign win_last = &pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q        <= '0;
      busy_q       <= '0;
      busy_latched <= '0;
      win_done     <= 1'b0;
    end else begin
      pos_q    <= pos_q + 1'b1;
      win_done <= win_last;
      if (win_last) begin
        busy_latched <= busy_q + CW'(crs);
        busy_q       <= '0;
      end else if (crs) begin
        busy_q <= busy_q + 1'b1;
      end
    end
  end

  // R3: busy cycles so far can never outnumber the cycles elapsed in the window
  assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    busy_q <= {1'b0, pos_q});

  // R2: the window-end pulse lasts a single cycle
  assert_single_done_R2: assert property (@(posedge clk) disable iff (rst)
    win_done |=> !win_done);

  // R3: a latched count never exceeds the window length
  assert_latch_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    win_done |-> busy_latched <= WIN_CYCLES);

  // R3: the running count moves only on carrier or at the window boundary
  assert_count_only_on_crs_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q != $past(busy_q)) |-> ($past(crs) || $past(win_last)));

endmodule

// File: rtl/util_band_encoder.sv
module util_band_encoder
  import util_meter_pkg::*;
#(
  parameter int WIN_LOG2 = 20,
  localparam int CW = WIN_LOG2 + 1
) (
  input  logic [CW-1:0]       busy,
  output logic [NUM_LEDS-1:0] bar_on
);

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_band
    localparam logic [CW-1:0] LIMIT = CW'(band_cycles(WIN_LOG2, i));
    assign bar_on[i] = busy > LIMIT;
  end

endmodule

// File: rtl/util_bar_display.sv
module util_bar_display
  import util_meter_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [NUM_LEDS-1:0] bar_on,
  output logic [NUM_LEDS-1:0] act_n
);

  logic [NUM_LEDS-1:0] lit;
  assign lit = ~act_n;

  always_ff @(posedge clk) begin
    if (rst)       act_n <= '1;
    else if (load) act_n <= ~bar_on;
  end

  // R6: the display moves only on the cycle after a window closes
  assert_hold_between_updates_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(act_n));

  // R5: lit LEDs form a solid bar from bit 0 with no gaps
  assert_solid_bar_R5: assert property (@(posedge clk) disable iff (rst)
    (lit & (lit + 1'b1)) == '0);

endmodule

// File: rtl/util_meter.sv
module util_meter
  import util_meter_pkg::*;
#(
  parameter int WIN_LOG2 = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       crs,
  output logic [7:0] act_n
);

  localparam int CW = WIN_LOG2 + 1;

  logic [CW-1:0]       busy_latched;
  logic                win_done;
  logic [NUM_LEDS-1:0] bar_on;

  util_busy_counter #(.WIN_LOG2(WIN_LOG2)) u_count (
    .clk          (clk),
    .rst          (rst),
    .crs          (crs),
    .busy_latched (busy_latched),
    .win_done     (win_done)
  );

  util_band_encoder #(.WIN_LOG2(WIN_LOG2)) u_band (
    .busy   (busy_latched),
    .bar_on (bar_on)
  );

  util_bar_display u_disp (
    .clk    (clk),
    .rst    (rst),
    .load   (win_done),
    .bar_on (bar_on),
    .act_n  (act_n)
  );

  // R8: a fully busy window lights the whole bar
  assert_full_window_R8: assert property (@(posedge clk) disable iff (rst)
    (win_done && busy_latched == (CW'(1) << WIN_LOG2)) |=> act_n == 8'h00);

  // R1: all LEDs stay dark during reset
  assert_reset_dark_R1: assert property (@(posedge clk)
    $past(rst) |-> act_n == 8'hFF);

endmodule

// File: tb/util_meter_tb.sv
module util_meter_tb;

  localparam int WL  = 10;
  localparam int WIN = 1 << WL;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crs = 1'b0;
  logic [7:0] act_n;

  int checks = 0;
  int fails  = 0;
  item_t sb[$];

  util_meter #(.WIN_LOG2(WL)) u_dut (
    .clk   (clk),
    .rst   (rst),
    .crs   (crs),
    .act_n (act_n)
  );

  always #5 clk = ~clk;

  // Windows to drive: busy counts and arrangement (1 = spread evenly)
  localparam int NW = 22;
  int nbusy[NW] = '{0, 10, 11, 20, 21, 40, 41, 81, 82, 163, 164,
                    327, 328, 655, 656, 819, 820, 1024, 500, 100, 11, 1024};
  bit spread[NW] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                     0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1};

  // Bench model: count percentages strictly exceeded, build active-low bar
  function automatic logic [7:0] model_bar(input int n);
    int pcts[8] = '{1, 2, 4, 8, 16, 32, 64, 80};
    int lit = 0;
    foreach (pcts[j]) if (n * 100 > pcts[j] * WIN) lit++;
    return ~((8'd1 << lit) - 8'd1) | ((lit == 8) ? 8'h00 : 8'h00);
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (act_n !== exp) begin
      fails++;
      $display("FAIL %s: act_n=%b expected=%b at %0t", tag, act_n, exp, $time);
    end
  endtask

  task automatic drive_all();
    for (int w = 0; w < NW; w++) begin
      item_t it;
      it.exp = (nbusy[w] >= WIN) ? 8'h00 : model_bar(nbusy[w]);
      if (spread[w]) it.tag = "R7 spread carrier";
      else if (nbusy[w] == 0 || nbusy[w] == WIN) it.tag = "R8 idle/full window";
      else it.tag = "R3/R4/R5 band threshold";
      sb.push_back(it);
      for (int k = 0; k < WIN; k++) begin
        if (spread[w]) crs = (((k + 1) * nbusy[w]) / WIN) != ((k * nbusy[w]) / WIN);
        else           crs = (k < nbusy[w]);
        @(negedge clk);
      end
    end
    crs = 1'b0;
  endtask

  task automatic monitor_all();
    logic [7:0] prev = 8'hFF;
    repeat (WIN) @(posedge clk);
    for (int w = 0; w < NW; w++) begin
      item_t it;
      @(negedge clk);
      check(prev, (w == 0) ? "R1 dark until first window" : "R2/R6 held until window end");
      @(posedge clk);
      @(negedge clk);
      it = sb.pop_front();
      check(it.exp, it.tag);
      prev = it.exp;
      repeat (WIN / 2) @(posedge clk);
      @(negedge clk);
      check(prev, "R6 steady mid-window");
      repeat (WIN / 2 - 1) @(posedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(8'hFF, "R1 reset state");
    rst = 1'b0;
    fork
      drive_all();
      monitor_all();
    join
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule